// File: doc/BRIEF.md
# Early Transmit Underrun Guard

This block sits between a host that is loading a transmit packet into buffer RAM and a transmit DMA engine that may already be reading the same packet out to the wire. While the early-transmit mode is on, it compares the address the DMA is about to read against the host's load pointer. If the DMA would overtake the data that has actually been written, the block stalls the DMA read and raises an underrun. The MAC then aborts the frame cleanly and does not send stale bytes.

Two compare modes exist. The plain mode compares addresses only. The packet-aware mode raises the hazard only when the DMA is reading the very packet the host is loading. A build parameter removes the mode-select bit, and the block then always uses the plain mode. The block can also start a transmission by itself: once the count of enqueued bytes reaches a programmable threshold, it issues one start request per packet. Otherwise a start comes only from an explicit host enqueue command.

Top module: `etx_guard`

## Requirements
- R1: While `early_en` is 0, `dma_stall` stays 0 and no underrun pulse is produced, whatever the addresses and packet numbers are.
- R2: With `early_en`=1 and the effective compare mode 0 (`cmp_pkt`=0), `dma_stall` equals (`dma_addr` > `host_ptr`) as 11-bit unsigned values, in the same cycle, whatever the packet numbers are.
- R3: With `early_en`=1 and the effective compare mode 1 (`cmp_pkt`=1), `dma_stall` is 1 only when `dma_pkt` == `host_pkt` and `dma_addr` > `host_ptr` (unsigned). Equal addresses never stall.
- R4: `underrun` is high in the cycle after a cycle in which `dma_rd` and `dma_stall` were both 1, and low otherwise.
- R5: `underrun_flag` sets in the cycle after `underrun` is high and holds until a cycle with `flag_clr`=1 and `underrun`=0. When `underrun`=1 and `flag_clr`=1 arrive together, the flag is set.
- R6: When the parameter `MODE_BIT_IMPL` is 0, the `cmp_pkt` input has no effect and the block compares as in R2.
- R7: When `auto_en`=1, `early_en`=1, `rcv_sel`=0, the packet is armed and `enq_bytes` >= `auto_thresh` (unsigned), `tx_start` is 1 in the next cycle.
- R8: The automatic start fires at most once per packet. After it fires, it stays quiet until `pkt_begin` re-arms it. `pkt_begin` wins over a simultaneous fire.
- R9: When `auto_en`=0, `early_en`=0 or `rcv_sel`=1, `tx_start` is 1 exactly in the cycle after `host_enq`=1 and 0 otherwise. `host_enq` also starts a transmit when automatic start is enabled.
- R10: After reset, `underrun`, `underrun_flag` and `tx_start` are 0, `dma_stall` follows the current inputs, and the automatic start is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_en | input | 1 | Early-transmit underrun guard enable |
| cmp_pkt | input | 1 | Compare mode: 0 address only, 1 packet number and address |
| auto_en | input | 1 | Automatic transmit start enable |
| rcv_sel | input | 1 | Receive-select control; 1 blocks automatic start |
| host_ptr | input | 11 | Host load pointer logical address |
| host_pkt | input | 6 | Packet number being loaded |
| dma_addr | input | 11 | Transmit DMA logical read address |
| dma_pkt | input | 6 | Packet number being transmitted |
| dma_rd | input | 1 | Transmit DMA read request |
| enq_bytes | input | 11 | Bytes enqueued so far for the current packet |
| auto_thresh | input | 11 | Byte count that triggers an automatic start |
| pkt_begin | input | 1 | A new packet begins; re-arms automatic start |
| host_enq | input | 1 | Explicit host enqueue command |
| flag_clr | input | 1 | Clears the sticky underrun flag |
| dma_stall | output | 1 | Combinational stall of DMA reads |
| underrun | output | 1 | Registered one-cycle underrun pulse |
| underrun_flag | output | 1 | Sticky underrun status |
| tx_start | output | 1 | Registered transmit start request |

## Verification
The address compare is driven with DMA addresses placed a few counts on either side of the load pointer, so each sample falls on one side of the strict greater-than boundary. Directed cases add equal addresses and the extremes 0 and 2047. Packet numbers are equal about half of the time, which separates the two compare modes. A second instance without the mode bit shows that the mode input is ignored. For the start logic, the random stream mixes enable, receive-select, threshold equality, re-arm and host enqueue. These cycles tell a once-per-packet automatic start apart from a repeating one, and also from starts by the host alone.

// File: rtl/etx_pkg.sv
package etx_pkg;
  localparam int ADDR_W = 11;
  localparam int PKT_W  = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PKT_W-1:0]  pkt_t;

  // unsigned "DMA has overtaken the load pointer"
  function automatic logic addr_ahead(input addr_t rd, input addr_t ld);
    return rd > ld;
  endfunction

  // full hazard decision for a given effective compare mode
  function automatic logic hazard(input logic en, input logic pkt_mode,
                                  input pkt_t rd_pkt, input pkt_t ld_pkt,
                                  input addr_t rd, input addr_t ld);
    logic same;
    same = (rd_pkt == ld_pkt);
    return en && addr_ahead(rd, ld) && (!pkt_mode || same);
  endfunction

  function automatic logic count_reached(input addr_t cnt, input addr_t thr);
    return cnt >= thr;
  endfunction
endpackage

// File: rtl/etx_cmp.sv
module etx_cmp
  import etx_pkg::*;
#(
  parameter bit MODE_BIT_IMPL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  early_en,
  input  logic  cmp_pkt,
  input  addr_t host_ptr,
  input  pkt_t  host_pkt,
  input  addr_t dma_addr,
  input  pkt_t  dma_pkt,
  output logic  stall,
  output logic  mode_eff
);
  logic ahead_w;
  logic pkt_same_w;

  // absent mode bit behaves as a cleared one
  assign mode_eff   = MODE_BIT_IMPL & cmp_pkt;
  assign ahead_w    = addr_ahead(dma_addr, host_ptr);
  assign pkt_same_w = (dma_pkt == host_pkt);
  assign stall      = hazard(early_en, mode_eff, dma_pkt, host_pkt, dma_addr, host_ptr);

  AST_STALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> early_en); // R1
  AST_STALL_NEEDS_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ahead_w); // R2
  AST_PKT_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mode_eff) |-> pkt_same_w); // R3
  AST_NO_MODE_WHEN_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE_BIT_IMPL == 1'b0) |-> !mode_eff); // R6
endmodule

// File: rtl/etx_urun.sv
module etx_urun (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_rd,
  input  logic stall,
  input  logic flag_clr,
  output logic pulse,
  output logic flag
);
  logic starve_ev;
  assign starve_ev = dma_rd & stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= starve_ev;
      if (pulse)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  AST_PULSE_AFTER_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
    starve_ev |=> pulse); // R4
  AST_PULSE_NEEDS_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
    !starve_ev |=> !pulse); // R4
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> flag); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R5
endmodule

// File: rtl/etx_auto.sv
module etx_auto
  import etx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  early_en,
  input  logic  auto_en,
  input  logic  rcv_sel,
  input  addr_t enq_bytes,
  input  addr_t auto_thresh,
  input  logic  pkt_begin,
  input  logic  host_enq,
  output logic  tx_start,
  output logic  auto_fire
);
  logic armed_q;
  logic auto_ok;

  assign auto_ok   = auto_en & early_en & ~rcv_sel;
  assign auto_fire = auto_ok & armed_q & count_reached(enq_bytes, auto_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      tx_start <= 1'b0;
    end else begin
      tx_start <= host_enq | auto_fire;
      if (pkt_begin)      armed_q <= 1'b1;
      else if (auto_fire) armed_q <= 1'b0;
    end
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fire && !pkt_begin) |=> !armed_q); // R8
  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fire |=> tx_start); // R7
  AST_NO_AUTO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_ok && !host_enq) |=> !tx_start); // R9
  AST_ENQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    host_enq |=> tx_start); // R9
endmodule

// File: rtl/etx_guard.sv
module etx_guard
  import etx_pkg::*;
#(
  parameter bit MODE_BIT_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_en,
  input  logic              cmp_pkt,
  input  logic              auto_en,
  input  logic              rcv_sel,
  input  logic [ADDR_W-1:0] host_ptr,
  input  logic [PKT_W-1:0]  host_pkt,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [PKT_W-1:0]  dma_pkt,
  input  logic              dma_rd,
  input  logic [ADDR_W-1:0] enq_bytes,
  input  logic [ADDR_W-1:0] auto_thresh,
  input  logic              pkt_begin,
  input  logic              host_enq,
  input  logic              flag_clr,
  output logic              dma_stall,
  output logic              underrun,
  output logic              underrun_flag,
  output logic              tx_start
);
  logic stall_w;
  logic mode_eff_w;
  logic auto_fire_w;

  etx_cmp #(.MODE_BIT_IMPL(MODE_BIT_IMPL)) u_cmp (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .cmp_pkt(cmp_pkt),
    .host_ptr(host_ptr), .host_pkt(host_pkt), .dma_addr(dma_addr),
    .dma_pkt(dma_pkt), .stall(stall_w), .mode_eff(mode_eff_w)
  );

  etx_urun u_urun (
    .clk(clk), .rst_n(rst_n), .dma_rd(dma_rd), .stall(stall_w),
    .flag_clr(flag_clr), .pulse(underrun), .flag(underrun_flag)
  );

  etx_auto u_auto (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .auto_en(auto_en),
    .rcv_sel(rcv_sel), .enq_bytes(enq_bytes), .auto_thresh(auto_thresh),
    .pkt_begin(pkt_begin), .host_enq(host_enq), .tx_start(tx_start),
    .auto_fire(auto_fire_w)
  );

  assign dma_stall = stall_w;

  AST_OFF_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_en) |=> !underrun); // R1
  AST_AUTO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fire_w |-> (early_en && !rcv_sel)); // R7
  AST_PKT_MODE_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stall && mode_eff_w) |-> (dma_pkt == host_pkt)); // R3
endmodule

// File: tb/test_etx_guard.sv
`timescale 1ns/1ps
module test_etx_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early_en = 0, cmp_pkt = 0, auto_en = 0, rcv_sel = 0;
  logic [10:0] host_ptr = 0, dma_addr = 0, enq_bytes = 0, auto_thresh = 0;
  logic [5:0]  host_pkt = 0, dma_pkt = 0;
  logic dma_rd = 0, pkt_begin = 0, host_enq = 0, flag_clr = 0;
  logic dma_stall, underrun, underrun_flag, tx_start;
  logic f_stall, f_underrun, f_flag, f_tx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected registered state
  bit e_pulse, e_flag, e_tx, e_armed;

  always #2.5 clk = ~clk;

  etx_guard #(.MODE_BIT_IMPL(1'b1)) i_etx_guard (
    .clk, .rst_n, .early_en, .cmp_pkt, .auto_en, .rcv_sel, .host_ptr, .host_pkt,
    .dma_addr, .dma_pkt, .dma_rd, .enq_bytes, .auto_thresh, .pkt_begin,
    .host_enq, .flag_clr, .dma_stall, .underrun, .underrun_flag, .tx_start);

  etx_guard #(.MODE_BIT_IMPL(1'b0)) i_etx_guard_fixed (
    .clk, .rst_n, .early_en, .cmp_pkt, .auto_en, .rcv_sel, .host_ptr, .host_pkt,
    .dma_addr, .dma_pkt, .dma_rd, .enq_bytes, .auto_thresh, .pkt_begin,
    .host_enq, .flag_clr, .dma_stall(f_stall), .underrun(f_underrun),
    .underrun_flag(f_flag), .tx_start(f_tx));

  // bench's own statement of the stall rule
  function automatic bit want_stall(bit en, bit mode, bit [5:0] pa, bit [5:0] pb,
                                    bit [10:0] rd, bit [10:0] ld);
    if (!en) return 0;
    if (int'(rd) <= int'(ld)) return 0;
    if (mode && (pa != pb)) return 0;
    return 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("R4 underrun", underrun, e_pulse);
    chk("R5 underrun_flag", underrun_flag, e_flag);
    chk("R7/R8/R9 tx_start", tx_start, e_tx);
  endtask

  // apply inputs (at negedge), check comb, advance model
  task automatic step();
    bit s, fire;
    #1;
    s = want_stall(early_en, cmp_pkt, dma_pkt, host_pkt, dma_addr, host_ptr);
    chk(early_en ? (cmp_pkt ? "R3 stall" : "R2 stall") : "R1 stall", dma_stall, s);
    chk("R6 stall fixed", f_stall,
        want_stall(early_en, 1'b0, dma_pkt, host_pkt, dma_addr, host_ptr));
    fire = auto_en && early_en && !rcv_sel && e_armed && (enq_bytes >= auto_thresh);
    e_flag  = e_pulse ? 1 : (flag_clr ? 0 : e_flag);
    e_pulse = dma_rd && s;
    e_tx    = host_enq || fire;
    e_armed = pkt_begin ? 1 : (fire ? 0 : e_armed);
    @(negedge clk);
    check_regs();
  endtask

  task automatic idle_inputs();
    early_en = 0; cmp_pkt = 0; auto_en = 0; rcv_sel = 0; dma_rd = 0;
    pkt_begin = 0; host_enq = 0; flag_clr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 underrun", underrun, 0);
    chk("R10 flag", underrun_flag, 0);
    chk("R10 tx_start", tx_start, 0);
    e_pulse = 0; e_flag = 0; e_tx = 0; e_armed = 1;

    // R1: guard off, DMA far ahead
    idle_inputs(); dma_rd = 1; host_ptr = 0; dma_addr = 11'd2047; step();
    // R2: extremes and equality
    early_en = 1; step();
    dma_addr = 11'd5; host_ptr = 11'd5; step();
    dma_addr = 11'd6; host_pkt = 6'd1; dma_pkt = 6'd2; step();
    // R3: packet mode, mismatch then match
    cmp_pkt = 1; step();
    dma_pkt = 6'd1; step();
    // R5: set and clear together -> set wins
    flag_clr = 1; step();
    dma_rd = 0; step();
    step();
    flag_clr = 0; step();
    // R7/R8: threshold equality, fire once, re-arm
    idle_inputs(); early_en = 1; auto_en = 1; enq_bytes = 11'd64; auto_thresh = 11'd64;
    step(); step(); step();
    pkt_begin = 1; step(); pkt_begin = 0; step();
    // R9: receive-select blocks, host enqueue still starts
    pkt_begin = 1; step(); pkt_begin = 0; rcv_sel = 1; step(); host_enq = 1; step();
    host_enq = 0; rcv_sel = 0; auto_en = 0; step();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int d;
      early_en  = ($urandom_range(0, 9) != 0);
      cmp_pkt   = $urandom_range(0, 1);
      auto_en   = $urandom_range(0, 1);
      rcv_sel   = ($urandom_range(0, 3) == 0);
      host_ptr  = 11'($urandom_range(0, 2047));
      d = $urandom_range(0, 6) - 3;
      dma_addr  = 11'(int'(host_ptr) + d);
      host_pkt  = 6'($urandom_range(0, 63));
      dma_pkt   = ($urandom_range(0, 1) != 0) ? host_pkt : 6'($urandom_range(0, 63));
      dma_rd    = $urandom_range(0, 1);
      auto_thresh = 11'($urandom_range(0, 15));
      enq_bytes = 11'($urandom_range(0, 15));
      pkt_begin = ($urandom_range(0, 7) == 0);
      host_enq  = ($urandom_range(0, 7) == 0);
      flag_clr  = ($urandom_range(0, 5) == 0);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule